// File: doc/BRIEF.md
# Audio Codec Configuration Sequencer

This block turns a handful of user-level audio settings into the ordered list of byte transfers that set up an audio codec over a three-wire control link. It does not drive the serial wires itself. Each byte goes to a separate serial master as a request flagged as either an address phase or a data phase, and the sequencer waits for that master's acknowledge before it presents the next byte.

A start pulse launches the power-up programme. The programme resets the codec, selects a 256fs system clock with standard I2S framing, powers the converters for playback and then writes volume, tone and mute. When the record select is high, three more writes follow: ADC power, an extended-register select and the input mixer setting. Volume, bass and treble arrive as 0..100 values. Each one is clamped, scaled to an inverted attenuation code and packed into its register byte.

After the programme has finished once, any change to a setting re-sends only the register pair it affects. A single-cycle done pulse marks the end of every completed programme or update.

Top module: `codec_init_seq`

## Requirements
- R1: After reset, no transfer is requested and done is low.
- R2: A start pulse issues exactly these twelve transfers, in this order, in playback mode. First come three status-register writes with data bytes 0x60 (reset bit 6 set, clock select bits 5:4 = 10, I2S format, no DC filter), 0x20 (the same with reset cleared) and 0x81 (DAC on, ADC off). Then come three data-register writes: volume, tone and mute.
- R3: An address byte is the device code 000101 in bits 7:2 with the register select in bits 1:0. The status register uses select 10 (byte 0x16) and the data register uses select 00 (byte 0x14).
- R4: The volume data byte is 63 − (v·63)/100, using truncating division, where v is the clamped volume.
- R5: The tone data byte is 0x40 + (bass code << 2) + treble code. The bass code is 14 − (b·14)/100 and the treble code is 3 − (t·3)/100.
- R6: The mute data byte is 0xA0, with bit 2 set when mute is high.
- R7: With record selected at start, the programme continues after mute with five more transfers: address 0x16, data 0xA2, address 0x14, data 0xC2, and then data 0x4D with no address phase of its own.
- R8: While a request is pending and not yet acknowledged, the request stays high and its phase flag and byte do not change. Each acknowledge consumes exactly one transfer.
- R9: Done is a single-cycle pulse in the cycle after the last transfer of a programme or update is acknowledged.
- R10: After the first programme, a change to a setting produces one address 0x14 plus its data byte, and only when the packed byte differs from the one last sent. When several bytes differ, they go out in the order volume, tone, mute.
- R11: Before the first start, setting changes produce no transfers. A start while a programme or update is running is ignored.
- R12: Setting values above 100 behave exactly as 100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Pulse that launches the power-up programme |
| record_i | input | 1 | High selects the record extension of the programme |
| volume_i | input | 7 | Volume setting, 0..100 (larger values clamp) |
| bass_i | input | 7 | Bass setting, 0..100 (larger values clamp) |
| treble_i | input | 7 | Treble setting, 0..100 (larger values clamp) |
| mute_i | input | 1 | Mute request |
| xfer_req_o | output | 1 | Transfer request to the serial master |
| xfer_addr_o | output | 1 | High when the byte is an address phase |
| xfer_byte_o | output | 8 | Byte to transfer |
| xfer_ack_i | input | 1 | Serial master has completed the pending transfer |
| done_o | output | 1 | Programme or update finished |

## Verification
The bench uses the default parameters: a 7-bit setting port, a full scale of 100 and the reciprocal-multiply divider. With these values every representable input from 0 to 127 can be swept on volume, bass and treble, so the clamp region and every point where consecutive settings map to the same code are reached. At those points no transfer may be issued. The acknowledge latency is varied from transfer to transfer, which tests the hold behaviour under different wait lengths. A second start is issued in the middle of the record programme to show that it is ignored.

// File: rtl/ccs_pkg.sv
package ccs_pkg;

   localparam int IDX_W = 5;

   typedef enum logic {
      SEQ_IDLE = 1'b0,
      SEQ_XFER = 1'b1
   } seq_state_e;

   // step numbers of the transfer list; update pairs reuse the programme slots
   localparam logic [IDX_W-1:0] STEP_VOL_A  = 5'd6;
   localparam logic [IDX_W-1:0] STEP_VOL_D  = 5'd7;
   localparam logic [IDX_W-1:0] STEP_TONE_A = 5'd8;
   localparam logic [IDX_W-1:0] STEP_TONE_D = 5'd9;
   localparam logic [IDX_W-1:0] STEP_MUTE_A = 5'd10;
   localparam logic [IDX_W-1:0] STEP_MUTE_D = 5'd11;
   localparam logic [IDX_W-1:0] STEP_LAST_PLAY = 5'd11;
   localparam logic [IDX_W-1:0] STEP_LAST_REC  = 5'd16;

   // register selects in the low two bits of an address byte
   localparam logic [1:0] SEL_DATA   = 2'b00;
   localparam logic [1:0] SEL_STATUS = 2'b10;

   // fixed data bytes
   localparam logic [7:0] CFG_RESET    = 8'h60;
   localparam logic [7:0] CFG_RUN      = 8'h20;
   localparam logic [7:0] PWR_PLAYBACK = 8'h81;
   localparam logic [7:0] PWR_RECORD   = 8'hA2;
   localparam logic [7:0] EXT_SELECT   = 8'hC2;
   localparam logic [7:0] EXT_MIXER    = 8'h4D;
   localparam logic [7:0] MUTE_BASE    = 8'hA0;
   localparam logic [7:0] TONE_BASE    = 8'h40;

endpackage

// File: rtl/ccs_scale.sv
module ccs_scale #(
   parameter  int SET_W     = 7,
   parameter  int FULL      = 100,
   parameter  int MAX_CODE  = 63,
   parameter  bit USE_RECIP = 1'b1,
   localparam int CODE_W    = $clog2(MAX_CODE + 1)
) (
   input  logic [SET_W-1:0]  set_i,
   output logic [CODE_W-1:0] code_o
);

   localparam int PROD_W = $clog2(FULL * MAX_CODE + 1);

   logic [SET_W-1:0]  sat;
   logic [PROD_W-1:0] prod;
   logic [CODE_W-1:0] quot;

   if (FULL >= (1 << SET_W)) begin : g_chk_full
      $error("ccs_scale: FULL does not fit in SET_W bits");
   end
   if (MAX_CODE < 1) begin : g_chk_max
      $error("ccs_scale: MAX_CODE must be positive");
   end

   assign sat  = (set_i > SET_W'(FULL)) ? SET_W'(FULL) : set_i;
   assign prod = PROD_W'(sat) * PROD_W'(MAX_CODE);

   if (USE_RECIP) begin : g_recip
      // truncating divide by FULL through a ceiling reciprocal of 2*PROD_W bits;
      // the excess of RECIP*FULL over 2^SH is below FULL, so no quotient shifts
      localparam int SH  = 2 * PROD_W;
      localparam int MW  = PROD_W + SH + 1;
      localparam logic [MW-1:0] RECIP = MW'(((64'd1 << SH) + 64'(FULL) - 64'd1) / 64'(FULL));
      if (SH > 48) begin : g_chk_sh
         $error("ccs_scale: reciprocal too wide");
      end
      assign quot = CODE_W'((MW'(prod) * RECIP) >> SH);
   end else begin : g_div
      assign quot = CODE_W'(prod / PROD_W'(FULL));
   end

   assign code_o = CODE_W'(MAX_CODE) - quot;

endmodule

// File: rtl/ccs_step_table.sv
module ccs_step_table
   import ccs_pkg::*;
#(
   parameter logic [5:0] DEV_CODE = 6'b000101
) (
   input  logic [IDX_W-1:0] idx_i,
   input  logic [7:0]       vol_byte_i,
   input  logic [7:0]       tone_byte_i,
   input  logic [7:0]       mute_byte_i,
   output logic             is_addr_o,
   output logic [7:0]       byte_o
);

   localparam logic [7:0] A_STATUS = {DEV_CODE, SEL_STATUS};
   localparam logic [7:0] A_DATA   = {DEV_CODE, SEL_DATA};

   always_comb begin
      is_addr_o = 1'b0;
      byte_o    = 8'h00;
      unique case (idx_i)
         5'd0:  begin is_addr_o = 1'b1; byte_o = A_STATUS;     end
         5'd1:  begin                   byte_o = CFG_RESET;    end
         5'd2:  begin is_addr_o = 1'b1; byte_o = A_STATUS;     end
         5'd3:  begin                   byte_o = CFG_RUN;      end
         5'd4:  begin is_addr_o = 1'b1; byte_o = A_STATUS;     end
         5'd5:  begin                   byte_o = PWR_PLAYBACK; end
         5'd6:  begin is_addr_o = 1'b1; byte_o = A_DATA;       end
         5'd7:  begin                   byte_o = vol_byte_i;   end
         5'd8:  begin is_addr_o = 1'b1; byte_o = A_DATA;       end
         5'd9:  begin                   byte_o = tone_byte_i;  end
         5'd10: begin is_addr_o = 1'b1; byte_o = A_DATA;       end
         5'd11: begin                   byte_o = mute_byte_i;  end
         5'd12: begin is_addr_o = 1'b1; byte_o = A_STATUS;     end
         5'd13: begin                   byte_o = PWR_RECORD;   end
         5'd14: begin is_addr_o = 1'b1; byte_o = A_DATA;       end
         5'd15: begin                   byte_o = EXT_SELECT;   end
         5'd16: begin                   byte_o = EXT_MIXER;    end
         default: begin is_addr_o = 1'b0; byte_o = 8'h00;      end
      endcase
   end

endmodule

// File: rtl/ccs_sequencer.sv
module ccs_sequencer
   import ccs_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             record_i,
   input  logic [7:0]       vol_byte_i,
   input  logic [7:0]       tone_byte_i,
   input  logic [7:0]       mute_byte_i,
   output logic [IDX_W-1:0] tbl_idx_o,
   input  logic             tbl_addr_i,
   input  logic [7:0]       tbl_byte_i,
   output logic             req_o,
   output logic             addr_o,
   output logic [7:0]       byte_o,
   input  logic             ack_i,
   output logic             done_o
);

   seq_state_e       state_q;
   logic [IDX_W-1:0] idx_q, last_q;
   logic             addr_q, done_q, inited_q;
   logic [7:0]       byte_q, sh_vol_q, sh_tone_q, sh_mute_q;

   logic             launch, take, finish;
   logic [IDX_W-1:0] l_idx, l_last;

   always_comb begin
      launch = 1'b0;
      l_idx  = '0;
      l_last = '0;
      if (state_q == SEQ_IDLE) begin
         if (start_i) begin
            launch = 1'b1;
            l_last = record_i ? STEP_LAST_REC : STEP_LAST_PLAY;
         end else if (inited_q) begin
            if (vol_byte_i != sh_vol_q) begin
               launch = 1'b1; l_idx = STEP_VOL_A;  l_last = STEP_VOL_D;
            end else if (tone_byte_i != sh_tone_q) begin
               launch = 1'b1; l_idx = STEP_TONE_A; l_last = STEP_TONE_D;
            end else if (mute_byte_i != sh_mute_q) begin
               launch = 1'b1; l_idx = STEP_MUTE_A; l_last = STEP_MUTE_D;
            end
         end
      end
   end

   assign take      = (state_q == SEQ_XFER) && ack_i;
   assign finish    = take && (idx_q == last_q);
   assign tbl_idx_o = (state_q == SEQ_IDLE) ? l_idx : IDX_W'(idx_q + 1'b1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= SEQ_IDLE;
         idx_q     <= '0;
         last_q    <= '0;
         addr_q    <= 1'b0;
         byte_q    <= 8'h00;
         done_q    <= 1'b0;
         inited_q  <= 1'b0;
         sh_vol_q  <= 8'h00;
         sh_tone_q <= 8'h00;
         sh_mute_q <= 8'h00;
      end else begin
         done_q <= finish;
         if (launch) begin
            state_q <= SEQ_XFER;
            idx_q   <= l_idx;
            last_q  <= l_last;
            addr_q  <= tbl_addr_i;
            byte_q  <= tbl_byte_i;
         end else if (take) begin
            case (idx_q)
               STEP_VOL_D:  sh_vol_q  <= byte_q;
               STEP_TONE_D: sh_tone_q <= byte_q;
               STEP_MUTE_D: sh_mute_q <= byte_q;
               default: ;
            endcase
            if (finish) begin
               state_q  <= SEQ_IDLE;
               inited_q <= 1'b1;
            end else begin
               idx_q  <= IDX_W'(idx_q + 1'b1);
               addr_q <= tbl_addr_i;
               byte_q <= tbl_byte_i;
            end
         end
      end
   end

   assign req_o  = (state_q == SEQ_XFER);
   assign addr_o = addr_q;
   assign byte_o = byte_q;
   assign done_o = done_q;

endmodule

// File: rtl/codec_init_seq.sv
module codec_init_seq
   import ccs_pkg::*;
#(
   parameter int         SET_W      = 7,
   parameter int         FULL_SCALE = 100,
   parameter int         VOL_MAX    = 63,
   parameter int         BASS_MAX   = 14,
   parameter int         TREB_MAX   = 3,
   parameter logic [5:0] DEV_CODE   = 6'b000101,
   parameter bit         USE_RECIP  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             record_i,
   input  logic [SET_W-1:0] volume_i,
   input  logic [SET_W-1:0] bass_i,
   input  logic [SET_W-1:0] treble_i,
   input  logic             mute_i,
   output logic             xfer_req_o,
   output logic             xfer_addr_o,
   output logic [7:0]       xfer_byte_o,
   input  logic             xfer_ack_i,
   output logic             done_o
);

   localparam int VOL_W  = $clog2(VOL_MAX + 1);
   localparam int BASS_W = $clog2(BASS_MAX + 1);
   localparam int TREB_W = $clog2(TREB_MAX + 1);

   if (VOL_W > 6)  begin : g_chk_vol  $error("VOL_MAX exceeds the 6-bit field");  end
   if (BASS_W > 4) begin : g_chk_bass $error("BASS_MAX exceeds the 4-bit field"); end
   if (TREB_W > 2) begin : g_chk_treb $error("TREB_MAX exceeds the 2-bit field"); end

   logic [VOL_W-1:0]  vol_code;
   logic [BASS_W-1:0] bass_code;
   logic [TREB_W-1:0] treb_code;
   logic [7:0]        vol_byte, tone_byte, mute_byte;
   logic [IDX_W-1:0]  tbl_idx;
   logic              tbl_addr;
   logic [7:0]        tbl_byte;

   ccs_scale #(.SET_W(SET_W), .FULL(FULL_SCALE), .MAX_CODE(VOL_MAX), .USE_RECIP(USE_RECIP))
      u_vol  (.set_i(volume_i), .code_o(vol_code));
   ccs_scale #(.SET_W(SET_W), .FULL(FULL_SCALE), .MAX_CODE(BASS_MAX), .USE_RECIP(USE_RECIP))
      u_bass (.set_i(bass_i),   .code_o(bass_code));
   ccs_scale #(.SET_W(SET_W), .FULL(FULL_SCALE), .MAX_CODE(TREB_MAX), .USE_RECIP(USE_RECIP))
      u_treb (.set_i(treble_i), .code_o(treb_code));

   assign vol_byte  = 8'(vol_code);
   assign tone_byte = TONE_BASE | (8'(bass_code) << 2) | 8'(treb_code);
   assign mute_byte = MUTE_BASE | {5'b0, mute_i, 2'b0};

   ccs_step_table #(.DEV_CODE(DEV_CODE)) u_tbl (
      .idx_i      (tbl_idx),
      .vol_byte_i (vol_byte),
      .tone_byte_i(tone_byte),
      .mute_byte_i(mute_byte),
      .is_addr_o  (tbl_addr),
      .byte_o     (tbl_byte)
   );

   ccs_sequencer u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .record_i   (record_i),
      .vol_byte_i (vol_byte),
      .tone_byte_i(tone_byte),
      .mute_byte_i(mute_byte),
      .tbl_idx_o  (tbl_idx),
      .tbl_addr_i (tbl_addr),
      .tbl_byte_i (tbl_byte),
      .req_o      (xfer_req_o),
      .addr_o     (xfer_addr_o),
      .byte_o     (xfer_byte_o),
      .ack_i      (xfer_ack_i),
      .done_o     (done_o)
   );

endmodule

// File: rtl/codec_init_seq_chk.sv
module codec_init_seq_chk #(
   parameter logic [5:0] DEV_CODE = 6'b000101
) (
   input logic       clk,
   input logic       rst_n,
   input logic       start_i,
   input logic       xfer_req_o,
   input logic       xfer_addr_o,
   input logic [7:0] xfer_byte_o,
   input logic       xfer_ack_i,
   input logic       done_o
);

   logic seen_start_q;

   always_ff @(posedge clk) begin
      if (!rst_n) seen_start_q <= 1'b0;
      else if (start_i) seen_start_q <= 1'b1;
   end

   AST_IDLE_AFTER_RESET: assert property (@(posedge clk)
      $rose(rst_n) |-> !xfer_req_o && !done_o); // R1

   AST_ADDR_BYTE_FORM: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_req_o && xfer_addr_o |->
         (xfer_byte_o == {DEV_CODE, 2'b10}) || (xfer_byte_o == {DEV_CODE, 2'b00})); // R3

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_req_o && !xfer_ack_i |=>
         xfer_req_o && $stable(xfer_byte_o) && $stable(xfer_addr_o)); // R8

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R9

   AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(xfer_ack_i) && $past(xfer_req_o) && !xfer_req_o); // R9

   AST_NO_WRITE_BEFORE_START: assert property (@(posedge clk) disable iff (!rst_n)
      !seen_start_q |-> !xfer_req_o); // R11

endmodule

bind codec_init_seq codec_init_seq_chk #(.DEV_CODE(DEV_CODE)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start_i    (start_i),
   .xfer_req_o (xfer_req_o),
   .xfer_addr_o(xfer_addr_o),
   .xfer_byte_o(xfer_byte_o),
   .xfer_ack_i (xfer_ack_i),
   .done_o     (done_o)
);

// File: tb/tb_codec_init_seq.sv
module tb_codec_init_seq;

   logic       clk = 1'b0, rst_n = 1'b0, start = 1'b0, rec = 1'b0, mute = 1'b0, ack = 1'b0;
   logic [6:0] vol = '0, bass = '0, treb = '0;
   logic       req, xaddr, done;
   logic [7:0] xbyte;

   always #4 clk = ~clk;

   codec_init_seq dut (
      .clk(clk), .rst_n(rst_n), .start_i(start), .record_i(rec),
      .volume_i(vol), .bass_i(bass), .treble_i(treb), .mute_i(mute),
      .xfer_req_o(req), .xfer_addr_o(xaddr), .xfer_byte_o(xbyte),
      .xfer_ack_i(ack), .done_o(done)
   );

   int n_chk = 0, n_fail = 0;
   logic [8:0] lg [64];
   logic [8:0] ex [64];
   int lg_n = 0, ex_n = 0, done_cnt = 0, done_dbl = 0, hold_err = 0, acked = 0;
   int wait_cnt = 0, lat = 1;
   logic p_req = 0, p_ack = 0, p_done = 0;
   logic [8:0] p_val = '0;
   int last_vol, last_tone, last_mute;

   function automatic int clampv(int v); return (v > 100) ? 100 : v; endfunction
   function automatic int e_vol(int v);  return 63 - (clampv(v) * 63) / 100; endfunction
   function automatic int e_tone(int b, int t);
      return 64 + ((14 - (clampv(b) * 14) / 100) << 2) + (3 - (clampv(t) * 3) / 100);
   endfunction
   function automatic int e_mute(int m); return 160 + (m != 0 ? 4 : 0); endfunction

   task automatic chk(bit ok, string tag, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic push(bit a, int b);
      ex[ex_n] = {a, 8'(b)};
      ex_n++;
   endtask

   task automatic clear_logs();
      lg_n = 0; ex_n = 0; done_cnt = 0;
   endtask

   task automatic cmp(string tag);
      chk(lg_n == ex_n, {tag, " transfer count"}, lg_n, ex_n);
      for (int i = 0; i < ex_n && i < lg_n; i++)
         chk(lg[i] == ex[i], {tag, " transfer {addr,byte}"}, int'(lg[i]), int'(ex[i]));
   endtask

   task automatic settle();
      int idle = 0;
      while (idle < 30) begin
         @(negedge clk); #1;
         if (req || ack) idle = 0; else idle++;
      end
   endtask

   task automatic pulse_start();
      @(negedge clk); #1; start = 1'b1;
      @(negedge clk); #1; start = 1'b0;
   endtask

   task automatic build_init(bit r);
      push(1, 'h16); push(0, 'h60); push(1, 'h16); push(0, 'h20);
      push(1, 'h16); push(0, 'h81);
      push(1, 'h14); push(0, e_vol(vol));
      push(1, 'h14); push(0, e_tone(bass, treb));
      push(1, 'h14); push(0, e_mute(mute));
      if (r) begin
         push(1, 'h16); push(0, 'hA2); push(1, 'h14); push(0, 'hC2); push(0, 'h4D);
      end
   endtask

   // models the serial master: acknowledges with a varying latency and logs each transfer
   initial begin
      forever begin
         @(negedge clk);
         if (!rst_n) begin
            ack = 1'b0; p_req = 1'b0; p_ack = 1'b0; p_done = 1'b0;
         end else begin
            if (p_req && !p_ack && (!req || {xaddr, xbyte} != p_val)) hold_err++;
            if (done) begin
               done_cnt++;
               if (p_done) done_dbl++;
            end
            p_done = done; p_req = req; p_val = {xaddr, xbyte};
            if (ack) ack = 1'b0;
            else if (req) begin
               wait_cnt++;
               if (wait_cnt >= lat) begin
                  ack = 1'b1; wait_cnt = 0;
                  if (lg_n < 64) lg[lg_n] = {xaddr, xbyte};
                  lg_n++; acked++;
                  lat = 1 + acked % 3;
               end
            end
            p_ack = ack;
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired, run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   task automatic step_update(string tag);
      int nv = e_vol(vol), nt = e_tone(bass, treb), nm = e_mute(mute), ne = 0;
      if (nv != last_vol)  begin push(1, 'h14); push(0, nv); ne++; end
      if (nt != last_tone) begin push(1, 'h14); push(0, nt); ne++; end
      if (nm != last_mute) begin push(1, 'h14); push(0, nm); ne++; end
      settle();
      cmp(tag);
      chk(done_cnt == ne, {tag, " done pulses"}, done_cnt, ne);
      last_vol = nv; last_tone = nt; last_mute = nm;
   endtask

   initial begin
      repeat (5) @(negedge clk);
      #1;
      chk(req == 1'b0, "R1 request after reset", int'(req), 0);
      chk(done == 1'b0, "R1 done after reset", int'(done), 0);
      rst_n = 1'b1;

      // R11: no transfers before the first start
      clear_logs();
      @(negedge clk); #1; vol = 7'd10; mute = 1'b1;
      settle();
      chk(lg_n == 0, "R11 transfers before start", lg_n, 0);

      // R2 R3 R4 R5 R6: playback programme
      vol = 7'd80; bass = 7'd0; treb = 7'd0; mute = 1'b0; rec = 1'b0;
      settle();
      clear_logs();
      build_init(1'b0);
      pulse_start();
      settle();
      cmp("R2 playback programme");
      chk(done_cnt == 1, "R9 done after programme", done_cnt, 1);
      last_vol = e_vol(vol); last_tone = e_tone(bass, treb); last_mute = e_mute(mute);

      // R4 R10 R12: volume sweep over every representable value
      for (int v = 0; v < 128; v++) begin
         clear_logs();
         @(negedge clk); #1; vol = 7'(v);
         step_update(v > 100 ? "R12 R4 volume clamp" : "R4 R10 volume sweep");
      end
      // R5 R10 R12: bass sweep with treble at mid scale, then treble sweep
      treb = 7'd50;
      clear_logs(); step_update("R5 treble preset");
      for (int b = 0; b < 128; b++) begin
         clear_logs();
         @(negedge clk); #1; bass = 7'(b);
         step_update(b > 100 ? "R12 R5 bass clamp" : "R5 R10 bass sweep");
      end
      bass = 7'd37;
      for (int t = 0; t < 128; t++) begin
         clear_logs();
         @(negedge clk); #1; treb = 7'(t);
         step_update(t > 100 ? "R12 R5 treble clamp" : "R5 R10 treble sweep");
      end
      // R6: mute on and off
      clear_logs(); @(negedge clk); #1; mute = 1'b1; step_update("R6 mute on");
      clear_logs(); @(negedge clk); #1; mute = 1'b0; step_update("R6 mute off");

      // R10: three changes at once go out as volume, tone, mute
      clear_logs();
      @(negedge clk); #1; vol = 7'd5; bass = 7'd100; treb = 7'd0; mute = 1'b1;
      step_update("R10 ordered multi update");

      // R7 R11: record programme with a second start in the middle
      clear_logs();
      rec = 1'b1;
      build_init(1'b1);
      pulse_start();
      repeat (10) @(negedge clk);
      #1; start = 1'b1; @(negedge clk); #1; start = 1'b0;
      settle();
      cmp("R7 R11 record programme");
      chk(done_cnt == 1, "R11 single done despite second start", done_cnt, 1);

      chk(hold_err == 0, "R8 request held until acknowledge", hold_err, 0);
      chk(done_dbl == 0, "R9 done single-cycle", done_dbl, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule